// File: doc/BRIEF.md
# Glitch-Free Clock Stop Sequencer

This block sits between a set of free-running clock sources and the pins that carry them out. It takes an asynchronous, active-low stop request and brings every output clock to a clean halt. After the halt it tells the analog side that the oscillator and loops may be powered off. When the request goes away it releases that power-down first, then lets each clock resume with a full-width first pulse.

The request is synchronized to the CPU reference clock. It only counts once it has been seen low on two consecutive rising edges of that clock. The qualified stop command is then passed into each output group's own domain through a two-flop synchronizer. In that domain an enable register clocked on the falling edge gates the clock, so a cut or a restart can only happen while the clock is already low. The CPU pair does not stop low. Its true side is held high and its complement side is released, which shows up as a low output enable. Each group reports back once it has stopped. Only when every report is in does the block raise its stopped status, and one reference cycle later the power-down enable.

Top module: `clkstop_seq`

## Requirements
- R1: After `rst` is released with `pd_n` high, `stopped` and `pll_off` are 0, `cpu_c_oe` is 1, and every bit of `grp_out` toggles.
- R2: A low on `pd_n` that is sampled on fewer than two consecutive rising edges of `clk_cpu` has no effect: `stopped` and `pll_off` stay 0 and `cpu_c_oe` stays 1.
- R3: While `pd_n` is held low, every bit of `grp_out` comes to rest at 0 and shows no further edge.
- R4: No high pulse on any bit of `grp_out`, on `cpu_t_out` or on `cpu_c_out` is shorter than half the period of its source clock, through both stop and restart. A group's enable changes only at a falling edge of that group's clock.
- R5: While parked, `cpu_t_out` is held at 1, `cpu_c_oe` is 0 and `cpu_c_out` is 0.
- R6: `stopped` is 1 only while every bit of `grp_out` is gated low and the CPU pair is parked.
- R7: With the request still held, `pll_off` rises after `stopped`. `pll_off` is 1 only while `stopped` is 1.
- R8: When `pd_n` returns high, `pll_off` falls while the outputs are still parked (`cpu_c_oe` = 0, `grp_out` = 0). The stop command stays asserted as long as `pll_off` is 1. After that every group toggles again and `cpu_c_oe` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | CPU reference clock; it is also the complement-phase source of the CPU pair |
| rst | input | 1 | Synchronous active-high reset; it must be held across several cycles of the slowest group clock |
| pd_n | input | 1 | Asynchronous active-low stop request |
| grp_clk | input | N_GRP | Free-running source clocks of the non-CPU output groups |
| grp_out | output | N_GRP | Gated group clocks |
| cpu_t_out | output | 1 | CPU true output: the inverse of `clk_cpu` when running, 1 when parked |
| cpu_c_out | output | 1 | CPU complement output value: `clk_cpu` when running |
| cpu_c_oe | output | 1 | Drive enable of the complement output; 0 means high impedance |
| stopped | output | 1 | All outputs have reached their parked state |
| pll_off | output | 1 | The oscillator and loops may be powered down |

## Verification
The assertions assume that every group clock runs continuously and that `rst` spans several of their cycles. They also assume that, after a release, `pd_n` stays high until every group has resumed, so that no stale acknowledge from an earlier stop can be taken as fresh. The bench keeps to these conditions. It starts each new stop only after it has watched every group toggle again. It drives `pd_n` at random times offset from all clock edges, uses five group clocks at unrelated periods, and exercises R2 with short lows that span exactly one rising edge.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;
  // depth of every clock-crossing synchronizer; two flops is the minimum
  localparam int SYNC_DEF = 2;
  // number of non-CPU output groups
  localparam int GRP_DEF = 5;
endpackage

// File: rtl/clkstop_sync.sv
`timescale 1ns/1ps
module clkstop_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= {STAGES{RST_VAL}};
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/clkstop_gate.sv
`timescale 1ns/1ps
module clkstop_gate #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic stop_cmd,
  output logic clk_out,
  output logic ack
);
  logic stop_s;
  logic en;

  clkstop_sync #(.STAGES(STAGES), .RST_VAL(1'b0)) u_stop_sync (
    .clk(clk), .rst(rst), .d(stop_cmd), .q(stop_s)
  );

  // enable moves only while clk is low, so the AND below never slices a pulse
  always_ff @(negedge clk) begin
    if (rst) en <= 1'b1;
    else     en <= ~stop_s;
  end

  assign clk_out = clk & en;
  assign ack     = ~en;

  // R4: enable follows the synchronized command one falling edge later
  a_r4_en_drops: assert property (@(negedge clk) disable iff (rst)
    stop_s |=> !en);
  a_r4_en_returns: assert property (@(negedge clk) disable iff (rst)
    !stop_s |=> en);
endmodule

// File: rtl/clkstop_cpu_park.sv
`timescale 1ns/1ps
module clkstop_cpu_park (
  input  logic ref_clk,
  input  logic rst,
  input  logic stop_cmd,
  output logic t_out,
  output logic c_out,
  output logic c_oe,
  output logic parked
);
  logic run;

  // switching at the falling edge of the complement: true is high at that moment
  always_ff @(negedge ref_clk) begin
    if (rst) run <= 1'b1;
    else     run <= ~stop_cmd;
  end

  assign t_out  = run ? ~ref_clk : 1'b1;
  assign c_out  = ref_clk & run;
  assign c_oe   = run;
  assign parked = ~run;

  // R5: park and unpark follow the command at the next falling edge
  a_r5_park: assert property (@(negedge ref_clk) disable iff (rst)
    stop_cmd |=> (!c_oe && t_out));
  a_r5_unpark: assert property (@(negedge ref_clk) disable iff (rst)
    !stop_cmd |=> c_oe);
endmodule

// File: rtl/clkstop_seq.sv
`timescale 1ns/1ps
module clkstop_seq
  import clkstop_pkg::*;
#(
  parameter int N_GRP       = GRP_DEF,
  parameter int SYNC_STAGES = SYNC_DEF
) (
  input  logic             clk_cpu,
  input  logic             rst,
  input  logic             pd_n,
  input  logic [N_GRP-1:0] grp_clk,
  output logic [N_GRP-1:0] grp_out,
  output logic             cpu_t_out,
  output logic             cpu_c_out,
  output logic             cpu_c_oe,
  output logic             stopped,
  output logic             pll_off
);
  logic             pd_s, pd_s_d;
  logic             stop_q, stop_cmd;
  logic             cpu_parked, all_ack;
  logic [N_GRP-1:0] grp_ack, grp_ack_s;

  clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pd_sync (
    .clk(clk_cpu), .rst(rst), .d(pd_n), .q(pd_s)
  );

  // qualified only after two consecutive low samples
  assign stop_q = ~pd_s & ~pd_s_d;

  always_ff @(posedge clk_cpu) begin
    if (rst) begin
      pd_s_d   <= 1'b1;
      stop_cmd <= 1'b0;
      stopped  <= 1'b0;
      pll_off  <= 1'b0;
    end else begin
      pd_s_d   <= pd_s;
      stop_cmd <= stop_q | pll_off;  // held one cycle past pll release
      stopped  <= stop_q & all_ack;
      pll_off  <= stop_q & stopped;
    end
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    clkstop_gate #(.STAGES(SYNC_STAGES)) u_gate (
      .clk(grp_clk[g]), .rst(rst), .stop_cmd(stop_cmd),
      .clk_out(grp_out[g]), .ack(grp_ack[g])
    );
    clkstop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ack_sync (
      .clk(clk_cpu), .rst(rst), .d(grp_ack[g]), .q(grp_ack_s[g])
    );
  end

  clkstop_cpu_park u_cpu (
    .ref_clk(clk_cpu), .rst(rst), .stop_cmd(stop_cmd),
    .t_out(cpu_t_out), .c_out(cpu_c_out), .c_oe(cpu_c_oe), .parked(cpu_parked)
  );

  assign all_ack = (&grp_ack_s) & cpu_parked;

  // R2: the stop command only starts after two low samples of the request
  a_r2_two_low_samples: assert property (@(posedge clk_cpu) disable iff (rst)
    $rose(stop_cmd) |-> (!$past(pd_s, 1) && !$past(pd_s, 2)));
  // R6: status implies every output is parked
  a_r6_stopped_parked: assert property (@(posedge clk_cpu) disable iff (rst)
    stopped |-> (grp_out == '0 && !cpu_c_oe && cpu_t_out));
  // R7: power-down enable only on top of the status
  a_r7_pll_needs_stopped: assert property (@(posedge clk_cpu) disable iff (rst)
    pll_off |-> stopped);
  // R8: no domain may restart while the power-down enable is still high
  a_r8_cmd_held: assert property (@(posedge clk_cpu) disable iff (rst)
    pll_off |-> stop_cmd);
endmodule

// File: tb/sim_clkstop_seq.sv
`timescale 1ns/1ps
module sim_clkstop_seq;
  localparam real CLK_PERIOD = 7.5;
  localparam int  NG         = 5;
  localparam real STEP       = 0.05;

  function automatic real gper(input int i);
    case (i)
      0:       return 15.0;
      1:       return 20.834;
      2:       return 30.0;
      3:       return 69.842;
      default: return 40.0;
    endcase
  endfunction

  logic          clk_cpu = 1'b0;
  logic          rst     = 1'b1;
  logic          pd_n    = 1'b1;
  logic [NG-1:0] grp_clk;
  logic [NG-1:0] grp_out;
  logic          cpu_t_out, cpu_c_out, cpu_c_oe, stopped, pll_off;

  always #(CLK_PERIOD/2.0) clk_cpu = ~clk_cpu;

  for (genvar g = 0; g < NG; g++) begin : g_clk
    logic c = 1'b0;
    initial forever #(gper(g)/2.0) c = ~c;
    assign grp_clk[g] = c;
  end

  clkstop_seq #(.N_GRP(NG)) u0 (
    .clk_cpu(clk_cpu), .rst(rst), .pd_n(pd_n), .grp_clk(grp_clk),
    .grp_out(grp_out), .cpu_t_out(cpu_t_out), .cpu_c_out(cpu_c_out),
    .cpu_c_oe(cpu_c_oe), .stopped(stopped), .pll_off(pll_off)
  );

  typedef enum {EXP_RESET, EXP_IGNORE, EXP_STOP, EXP_RUN} exp_e;
  exp_e sbq[$];
  int   pushed = 0, done_cnt = 0;
  int   n_chk = 0, n_err = 0, p_chk = 0, p_err = 0;
  logic armed = 1'b0;

  // ---------------- monitor side ----------------
  int  w_tog [NG];
  int  w_grp_hi, w_t_lo, w_oe_lo, w_oe_hi, w_c_hi, w_pll_hi, w_stp_hi;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic watch(input real dur);
    logic [NG-1:0] prev;
    for (int i = 0; i < NG; i++) w_tog[i] = 0;
    w_grp_hi = 0; w_t_lo = 0; w_oe_lo = 0; w_oe_hi = 0;
    w_c_hi = 0; w_pll_hi = 0; w_stp_hi = 0;
    prev = grp_out;
    repeat (int'(dur/STEP)) begin
      #STEP;
      for (int i = 0; i < NG; i++) if (grp_out[i] !== prev[i]) w_tog[i]++;
      if (grp_out !== '0)   w_grp_hi++;
      if (cpu_t_out !== 1)  w_t_lo++;
      if (cpu_c_oe !== 1)   w_oe_lo++;
      if (cpu_c_oe !== 0)   w_oe_hi++;
      if (cpu_c_out !== 0)  w_c_hi++;
      if (pll_off !== 0)    w_pll_hi++;
      if (stopped !== 0)    w_stp_hi++;
      prev = grp_out;
    end
  endtask

  // sel 0: pll_off, sel 1: stopped
  task automatic wait_sig(input int sel, input logic val, output logic ok);
    ok = 1'b0;
    repeat (int'(3000.0/STEP)) begin
      if ((sel == 0 ? pll_off : stopped) === val) begin ok = 1'b1; break; end
      #STEP;
    end
  endtask

  initial begin : monitor
    exp_e item;
    logic ok;
    forever begin
      while (sbq.size() == 0) #1;
      item = sbq.pop_front();
      case (item)
        EXP_RESET: begin
          chk("R1", "stopped after reset", stopped, 0);
          chk("R1", "pll_off after reset", pll_off, 0);
          chk("R1", "cpu_c_oe after reset", cpu_c_oe, 1);
          watch(200.0);
          for (int i = 0; i < NG; i++) chk("R1", "group toggles", w_tog[i] > 0, 1);
        end
        EXP_IGNORE: begin
          watch(400.0);
          chk("R2", "pll_off samples high", w_pll_hi, 0);
          chk("R2", "stopped samples high", w_stp_hi, 0);
          chk("R2", "cpu_c_oe samples low", w_oe_lo, 0);
        end
        EXP_STOP: begin
          wait_sig(1, 1'b1, ok);
          chk("R6", "stopped reached", ok, 1);
          chk("R6", "groups low at status", grp_out, 0);
          chk("R6", "complement released at status", cpu_c_oe, 0);
          chk("R6", "true high at status", cpu_t_out, 1);
          wait_sig(0, 1'b1, ok);
          chk("R7", "pll_off reached", ok, 1);
          chk("R7", "stopped with pll_off", stopped, 1);
          watch(300.0);
          for (int i = 0; i < NG; i++) chk("R3", "group edges while stopped", w_tog[i], 0);
          chk("R3", "group high samples", w_grp_hi, 0);
          chk("R5", "true low samples", w_t_lo, 0);
          chk("R5", "oe high samples", w_oe_hi, 0);
          chk("R5", "complement value high samples", w_c_hi, 0);
        end
        default: begin
          wait_sig(0, 1'b0, ok);
          chk("R8", "pll_off released", ok, 1);
          chk("R8", "oe still low at pll release", cpu_c_oe, 0);
          chk("R8", "groups still low at pll release", grp_out, 0);
          wait_sig(1, 1'b0, ok);
          chk("R8", "stopped cleared", ok, 1);
          #20;
          watch(300.0);
          for (int i = 0; i < NG; i++) chk("R8", "group resumes", w_tog[i] > 0, 1);
          chk("R8", "oe low samples after resume", w_oe_lo, 0);
        end
      endcase
      done_cnt++;
    end
  end

  // ---------------- pulse width checker (R4) ----------------
  real t_up [NG+2];
  initial begin : pulse_chk
    logic [NG+1:0] pv, cur;
    real half, width;
    for (int i = 0; i < NG+2; i++) t_up[i] = -1.0;
    pv = '0;
    forever begin
      #STEP;
      cur = {cpu_c_out, cpu_t_out, grp_out};
      if (armed) begin
        for (int i = 0; i < NG+2; i++) begin
          if (cur[i] === 1'b1 && pv[i] !== 1'b1) t_up[i] = $realtime;
          if (cur[i] === 1'b0 && pv[i] === 1'b1 && t_up[i] >= 0.0) begin
            width = $realtime - t_up[i];
            half  = (i < NG) ? gper(i)/2.0 : CLK_PERIOD/2.0;
            p_chk++;
            if (width < half - 0.2) begin
              p_err++;
              $display("FAIL R4: output %0d high pulse actual=%0.3f ns expected>=%0.3f ns",
                       i, width, half);
            end
          end
        end
      end else begin
        for (int i = 0; i < NG+2; i++) t_up[i] = -1.0;
      end
      pv = cur;
    end
  end

  // ---------------- driver ----------------
  task automatic push(input exp_e e);
    sbq.push_back(e);
    pushed++;
  endtask

  task automatic settle();
    while (done_cnt != pushed) #1;
  endtask

  initial begin : driver
    void'($urandom(32'h3c1a));
    rst = 1'b1;
    repeat (60) @(posedge clk_cpu);
    #1 rst = 1'b0;
    #200 armed = 1'b1;
    push(EXP_RESET);
    settle();
    // R2: short lows that cover exactly one rising edge
    for (int k = 0; k < 2; k++) begin
      push(EXP_IGNORE);
      @(posedge clk_cpu);
      #(1.0 + 2.0*k) pd_n = 1'b0;
      #(CLK_PERIOD - 0.5 - 2.0*k) pd_n = 1'b1;
      settle();
    end
    // R3, R5, R6, R7, R8: full stop/restart cycles at random times
    for (int k = 0; k < 5; k++) begin
      #($urandom_range(5, 80) + 0.3);
      push(EXP_STOP);
      pd_n = 1'b0;
      settle();
      #($urandom_range(5, 80) + 0.7);
      push(EXP_RUN);
      pd_n = 1'b1;
      settle();
    end
    armed = 1'b0;
    #10;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + p_chk, n_err + p_err);
    $finish;
  end

  initial begin : watchdog
    #60000;
    $display("FAIL watchdog: run incomplete actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + p_chk + 1, n_err + p_err + 1);
    $finish;
  end
endmodule